// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs read and write cycles on an external memory and I/O bus for an 8-bit processor core. The 16-bit address is split. Its low byte is sent on an 8-bit bus that later carries the data. Its high byte goes out on dedicated lines. Two active-low strobes frame each cycle. The address strobe marks the address phase, and its rising edge latches the low byte into an external register. The data strobe marks the data phase. A read/write line and an active-low data-memory select stay valid for the whole cycle.

Every cycle has three clocks: T1, T2 and T3. A slow device can add wait clocks by holding the active-low wait input low. An extended-timing option, chosen per request, adds a fixed stretch of clocks to every cycle. On the core side, a request is accepted while the controller is idle. The core holds the request until a one-clock done pulse. On a read, the read data is valid in the same clock as the done pulse.

The low-byte bus is modelled as separate output, output-enable and input pins. The pad driver is outside the block. All strobe edges fall on clock edges.

Top module: `xbus_master`

## Requirements
- R1: The controller accepts a request on a clock edge while idle. In the next clock (T1), `asN` is low, `adOe` is high, `adOut` equals address bits 7..0 and `addrHi` equals address bits 15..8. `asN` is high in every other clock.
- R2: From T1 through T3, `rwN` is 1 for a read and 0 for a write. `dmN` is 0 when `reqDataMem` was 1 and 1 otherwise. Both values stay unchanged for the whole cycle.
- R3: On a read, `adOe` is low in every clock in which `dsN` is low. `rspRdata` equals `adIn` in the clock in which `rspDone` is high.
- R4: On a write, `adOe` is high and `adOut` equals the write data in every clock in which `dsN` is low.
- R5: `dsN` goes low in the clock after T1 and stays low through T3. `asN` and `dsN` are never low together.
- R6: Without extended timing and with `waitN` high, a cycle is exactly 3 clocks. `dsN` is low for 2 of them.
- R7: `waitN` is sampled at the end of the last clock before any wait clocks, and again at the end of each wait clock. Each sample that finds it low adds one clock with `dsN` low. The first high sample moves the cycle to T3.
- R8: When `extTiming` is 1 at acceptance, `EXT_CLKS` clocks (default 2) with `dsN` low are added after T2, before `waitN` is first sampled.
- R9: `rspDone` is high for exactly one clock, the last clock of a cycle (T3). The following clock is idle.
- R10: While idle, including after reset, `asN`=1, `dsN`=1, `adOe`=0, `rwN`=1, `dmN`=1 and `rspDone`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request, held until `rspDone` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDataMem | input | 1 | 1 selects data memory (drives `dmN` low) |
| extTiming | input | 1 | 1 = add the extended-timing stretch to this cycle |
| reqAddr | input | 16 | Cycle address |
| reqWdata | input | 8 | Write data |
| rspDone | output | 1 | One-clock completion pulse |
| rspRdata | output | 8 | Read data, valid with `rspDone` |
| adOut | output | 8 | Shared bus output value |
| adOe | output | 1 | Shared bus output enable |
| adIn | input | 8 | Shared bus input value |
| addrHi | output | 8 | Address bits 15..8 |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| rwN | output | 1 | 1 = read, 0 = write |
| dmN | output | 1 | Data-memory select, active low |
| waitN | input | 1 | Wait request, active low |

## Verification
The address phase is due in the clock after the acceptance edge. It shows up as the first falling-clock sample with `asN` low, and the scoreboard pops the expected item at that point. The data phase is counted in falling-edge samples of `dsN` low. The count must equal 2 plus the stretch plus the number of low wait samples. `rspDone` and the read data are due in the last of those samples, and the sample after it must be idle. The bench model of the external device drives `waitN` from that same count, so each wait sample falls on the edge the requirements name.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TX, ST_TW, ST_T3
  } busState_e;

  typedef struct packed {
    logic load;     // capture request fields
    logic drvAddr;  // low address on shared bus
    logic drvData;  // data phase (write data if writing)
    logic asAct;
    logic dsAct;
    logic inCycle;  // T1..T3
    logic done;
  } busStrobe_t;
endpackage

// File: rtl/xbc_ctrl.sv
module xbc_ctrl
  import xbc_pkg::*;
#(
  parameter int EXT_CLKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       extTiming,
  input  logic       waitN,
  output busStrobe_t stb
);
  localparam int CW = $clog2(EXT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(EXT_CLKS - 1);

  busState_e state, nextState;
  logic [CW-1:0] extCnt;
  logic          extLat;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (reqValid) nextState = ST_T1;
      ST_T1:   nextState = ST_T2;
      ST_T2:   if (extLat)     nextState = ST_TX;
               else if (!waitN) nextState = ST_TW;
               else             nextState = ST_T3;
      ST_TX:   if (extCnt == LAST) nextState = waitN ? ST_T3 : ST_TW;
      ST_TW:   if (waitN) nextState = ST_T3;
      ST_T3:   nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      extCnt <= '0;
      extLat <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && reqValid) extLat <= extTiming;
      if (state == ST_TX) extCnt <= extCnt + 1'b1;
      else                extCnt <= '0;
    end
  end

  always_comb begin
    stb         = '0;
    stb.load    = (state == ST_IDLE) && reqValid;
    stb.drvAddr = (state == ST_T1);
    stb.asAct   = (state == ST_T1);
    stb.dsAct   = (state == ST_T2) || (state == ST_TX) ||
                  (state == ST_TW) || (state == ST_T3);
    stb.drvData = stb.dsAct;
    stb.inCycle = stb.asAct || stb.dsAct;
    stb.done    = (state == ST_T3);
  end
endmodule

// File: rtl/xbc_datapath.sv
module xbc_datapath
  import xbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic              reqWrite,
  input  logic              reqDataMem,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic              asN,
  output logic              dsN,
  output logic              rwN,
  output logic              dmN,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata
);
  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] wdataR;
  logic              writeR, dmR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      wdataR <= '0;
      writeR <= 1'b0;
      dmR    <= 1'b0;
    end else if (stb.load) begin
      addrR  <= reqAddr;
      wdataR <= reqWdata;
      writeR <= reqWrite;
      dmR    <= reqDataMem;
    end
  end

  assign adOe     = stb.drvAddr || (stb.drvData && writeR);
  assign adOut    = stb.drvAddr ? addrR[DATA_W-1:0] : wdataR;
  assign addrHi   = addrR[ADDR_W-1:DATA_W];
  assign asN      = ~stb.asAct;
  assign dsN      = ~stb.dsAct;
  assign rwN      = stb.inCycle ? ~writeR : 1'b1;
  assign dmN      = stb.inCycle ? ~dmR : 1'b1;
  assign rspDone  = stb.done;
  assign rspRdata = (stb.done && !writeR) ? adIn : '0;
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int EXT_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqDataMem,
  input  logic              extTiming,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic              asN,
  output logic              dsN,
  output logic              rwN,
  output logic              dmN,
  input  logic              waitN
);
  busStrobe_t stb;

  xbc_ctrl #(.EXT_CLKS(EXT_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .extTiming(extTiming), .waitN(waitN), .stb(stb)
  );

  xbc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqWrite(reqWrite), .reqDataMem(reqDataMem),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .addrHi(addrHi),
    .asN(asN), .dsN(dsN), .rwN(rwN), .dmN(dmN),
    .rspDone(rspDone), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rspDone,
  input logic [DATA_W-1:0] adOut,
  input logic              adOe,
  input logic              asN,
  input logic              dsN,
  input logic              rwN,
  input logic              dmN
);
  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!asN && !dsN));

  assert_ds_follows_as_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asN) |-> !dsN);

  assert_ctl_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && !$past(dsN)) |-> ($stable(rwN) && $stable(dmN)));

  assert_read_released_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && rwN) |-> !adOe);

  assert_write_driven_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && !rwN) |-> (adOe && $stable(adOut)) || $fell(dsN));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> (!rspDone && asN && dsN));

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    (asN && dsN) |-> (!adOe && rwN && dmN));
endmodule

bind xbus_master xbus_master_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_xbus_master.sv
module sim_xbus_master;
  typedef struct {
    bit         wr;
    logic [15:0] addr;
    logic [7:0]  data;
    bit         dm;
    bit         ext;
    int         nWait;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqDataMem = 1'b0, extTiming = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic rspDone, adOe, asN, dsN, rwN, dmN;
  logic [7:0] rspRdata, adOut, addrHi, adIn;
  logic waitN = 1'b1;
  logic [15:0] latAddr = '0;

  int tests = 0, fails = 0, cyc = 0;
  item_t q[$];

  always #4 clk = ~clk;

  xbus_master u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqDataMem(reqDataMem), .extTiming(extTiming), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspDone(rspDone), .rspRdata(rspRdata),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .addrHi(addrHi),
    .asN(asN), .dsN(dsN), .rwN(rwN), .dmN(dmN), .waitN(waitN)
  );

  function automatic logic [7:0] devData(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign adIn = devData(latAddr);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  item_t cur;
  bit active = 0, doneSeen = 0, busOk = 1, ctlOk = 1;
  int dsCnt = 0, lim = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!asN && !active) begin
        cur = q.pop_front();
        active = 1; dsCnt = 0; busOk = 1; ctlOk = 1;
        lim = (cur.ext ? 2 : 0) + cur.nWait;
        latAddr = {addrHi, adOut};
        chk(adOe && adOut == cur.addr[7:0], "R1 low address", {adOe, adOut}, {1'b1, cur.addr[7:0]});
        chk(addrHi == cur.addr[15:8], "R1 high address", addrHi, cur.addr[15:8]);
        chk(rwN == !cur.wr && dmN == !cur.dm, "R2 rw/dm", {rwN, dmN}, {!cur.wr, !cur.dm});
      end else if (!dsN && active) begin
        dsCnt++;
        waitN = (dsCnt > lim);
        if (!asN) ctlOk = 0;
        if (rwN != !cur.wr || dmN != !cur.dm) ctlOk = 0;
        if (cur.wr) begin
          if (!(adOe && adOut == cur.data)) busOk = 0;
        end else if (adOe) busOk = 0;
        if (rspDone) begin
          chk(dsCnt == lim + 2,
              cur.ext ? "R8 extended length" : (cur.nWait > 0 ? "R7 wait length" : "R6 base length"),
              dsCnt, lim + 2);
          chk(ctlOk, "R2 R5 rw/dm stable, strobes exclusive", ctlOk, 1);
          if (cur.wr) chk(busOk, "R4 write data on bus", busOk, 1);
          else begin
            chk(busOk, "R3 bus released on read", busOk, 1);
            chk(rspRdata == devData(cur.addr), "R3 read data", rspRdata, devData(cur.addr));
          end
          active = 0; waitN = 1'b1; doneSeen = 1;
        end
      end else if (doneSeen) begin
        chk(!rspDone && asN && dsN && !adOe && rwN && dmN, "R9 R10 idle after done",
            {rspDone, asN, dsN, adOe, rwN, dmN}, 6'b011011);
        doneSeen = 0;
      end
      if (active && asN && dsN) chk(0, "R5 strobe gap in cycle", {asN, dsN}, 2'b00);
    end
  end

  task automatic runCycle(bit wr, logic [15:0] a, logic [7:0] d, bit dm, bit ext, int nw);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d; it.dm = dm; it.ext = ext; it.nWait = nw;
    q.push_back(it);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    reqDataMem = dm; extTiming = ext;
    do @(negedge clk); while (!rspDone);
    reqValid = 0; reqWrite = 0; extTiming = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++; tests++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(asN && dsN && !adOe && rwN && dmN && !rspDone, "R10 reset state",
        {asN, dsN, adOe, rwN, dmN, rspDone}, 6'b110110);
    rstN = 1;
    @(negedge clk);
    runCycle(0, 16'h1234, 8'h00, 0, 0, 0);   // R6 read
    runCycle(1, 16'hABCD, 8'hC3, 1, 0, 0);   // R4 write, data memory
    runCycle(0, 16'h0000, 8'h00, 1, 0, 0);   // boundary address
    runCycle(1, 16'hFFFF, 8'h3C, 0, 0, 0);
    runCycle(0, 16'h8001, 8'h00, 0, 0, 1);   // R7 one wait
    runCycle(1, 16'h7F80, 8'hA5, 1, 0, 3);   // R7 three waits
    runCycle(0, 16'h55AA, 8'h00, 1, 1, 0);   // R8 extended read
    runCycle(1, 16'hAA55, 8'h5A, 0, 1, 0);   // R8 extended write
    runCycle(0, 16'h0F0F, 8'h00, 0, 1, 2);   // R8 + R7
    runCycle(1, 16'hF0F0, 8'hFF, 1, 1, 1);
    runCycle(0, 16'h2468, 8'h00, 0, 0, 0);   // back to base length after ext
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9 all cycles completed", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule